// File: doc/BRIEF.md
# Predicated Vector Element Step Sequencer

This block steps one instruction of a scalar core across the elements of a vector. The core fetches the instruction once. The sequencer then supplies a source element index and a destination element index for each element. It holds the program counter while elements remain. When the instruction is complete, it releases the program counter.

Each index can be gated by a predicate mask. On a side without zeroing, lanes whose predicate bit is clear are skipped. On a side with zeroing, the index stays where it is and a zero flag asks the datapath to write zero for that lane.

A `start` pulse latches the vector length, the masks and the operand flags, and places the first lanes. Each `done` pulse marks one finished element and moves the indices to the next pair of lanes, or ends the loop. When the loop ends, both indices return to 0 and a one-cycle end pulse is raised. The end pulse lets the core advance its program counter.

Top module: `vec_step_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both indices and both zero flags to 0, and deasserts `hold_pc` and `loop_end`.
- R2: At the clock edge where `start` is high, the sequencer latches the length, masks and flags, and places the first lane pair. All outputs are registered: they show the result from the edge that follows the `start` or `done` pulse.
- R3: Mask choice depends on two inputs. With `pred_en` low, both masks are all ones. With `pred_en` high and `twin_pred` low, the destination mask gates both indices. With both high, the source index uses `src_mask_in` and the destination index uses `dst_mask_in`.
- R4: A side without zeroing moves to the lowest lane at or above its candidate index whose mask bit (bit i for lane i) is 1 and which lies below VL. Mask bits at or above VL are ignored. If no such lane exists, the search result equals VL.
- R5: A side with zeroing keeps its candidate index. Its zero flag is 1 exactly when the mask bit of that lane is 0.
- R6: If either search result equals VL, the loop ends. Both indices and flags become 0, `hold_pc` goes low, and `loop_end` is high for that one cycle.
- R7: A `start` with VL = 0 ends the loop at once, with no element issued.
- R8: The operation counts as vector in two cases. With twin predication, it is vector when `in_vec` or `out_vec` is set. With single predication, it is vector only when `out_vec` is set. After a `done`, a non-vector operation ends the loop.
- R9: On `done` while `hold_pc` is high, if the operation is vector and neither index equals VL-1, the candidates become index+1 on both sides and `hold_pc` stays high. Otherwise the loop ends as in R6.
- R10: `done` while `hold_pc` is low changes nothing. A `start` during a running loop restarts the sequence from lane 0 with the new settings.
- R11: A `vl_in` above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new instruction, latching the settings |
| done | input | 1 | Current element finished |
| vl_in | input | 7 | Vector length |
| src_mask_in | input | 64 | Source predicate mask, bit i for lane i |
| dst_mask_in | input | 64 | Destination predicate mask, bit i for lane i |
| pred_en | input | 1 | Predication in use |
| twin_pred | input | 1 | Separate source and destination masks |
| src_zero_en | input | 1 | Zero masked source lanes instead of skipping them |
| dst_zero_en | input | 1 | Zero masked destination lanes instead of skipping them |
| in_vec | input | 1 | An input operand is a vector |
| out_vec | input | 1 | The output operand is a vector |
| src_idx | output | 7 | Current source element index |
| dst_idx | output | 7 | Current destination element index |
| src_zero | output | 1 | Source lane must read as zero |
| dst_zero | output | 1 | Destination lane must be written as zero |
| hold_pc | output | 1 | Loop running: keep the program counter |
| loop_end | output | 1 | One-cycle pulse: loop finished, program counter may advance |

## Verification
The bench uses random masks of three densities: dense, sparse, and empty. Dense masks test the plain one-by-one stepping. Sparse masks test multi-lane skips and early endings where one side runs out of lanes. Empty masks test termination before any element is issued. The masks are combined with each predication mode and each zeroing setting, which tells apart the shared single mask from the separate twin masks, and skipping from zeroing. Directed cases cover VL of 0, 1 and above 64, set mask bits beyond VL, and scalar versus vector operands under single and twin predication.

// File: rtl/vss_pkg.sv
package vss_pkg;
  parameter int unsigned LANES = 64;
  parameter int unsigned IDX_W = $clog2(LANES + 1);

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [LANES-1:0] mask_t;

  typedef struct packed {
    idx_t  vl;
    mask_t smask;
    mask_t dmask;
    logic  szero;
    logic  dzero;
    logic  vec;
  } cfg_t;

  // saturate the requested length at the lane count
  function automatic idx_t clamp_vl(input idx_t v);
    return (v > idx_t'(LANES)) ? idx_t'(LANES) : v;
  endfunction

  // lowest set lane in [from, vl), or vl if none
  function automatic idx_t seek_lane(input mask_t m, input idx_t from, input idx_t vl);
    idx_t r;
    logic hit;
    r   = vl;
    hit = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (!hit && m[i] && idx_t'(i) >= from && idx_t'(i) < vl) begin
        r   = idx_t'(i);
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  // vector classification used by the post-element decision
  function automatic logic is_vector(input logic twin, input logic in_v, input logic out_v);
    return twin ? (in_v | out_v) : out_v;
  endfunction
endpackage

// File: rtl/vss_cfg_latch.sv
module vss_cfg_latch
  import vss_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  idx_t  vl_in,
  input  mask_t src_mask_in,
  input  mask_t dst_mask_in,
  input  logic  pred_en,
  input  logic  twin_pred,
  input  logic  src_zero_en,
  input  logic  dst_zero_en,
  input  logic  in_vec,
  input  logic  out_vec,
  output cfg_t  cfg_next,
  output cfg_t  cfg_q
);
  cfg_t cfg_in;

  always_comb begin
    cfg_in.vl    = clamp_vl(vl_in);
    cfg_in.dmask = pred_en ? dst_mask_in : '1;
    cfg_in.smask = !pred_en ? '1 : (twin_pred ? src_mask_in : dst_mask_in);
    cfg_in.szero = src_zero_en;
    cfg_in.dzero = dst_zero_en;
    cfg_in.vec   = is_vector(twin_pred, in_vec, out_vec);
  end

  assign cfg_next = start ? cfg_in : cfg_q;

  always_ff @(posedge clk) begin
    if (rst)        cfg_q <= '0;
    else if (start) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/vss_lane_seek.sv
module vss_lane_seek
  import vss_pkg::*;
(
  input  mask_t mask,
  input  idx_t  from,
  input  idx_t  vl,
  input  logic  zero_en,
  output idx_t  idx,
  output logic  zflag
);
  mask_t shifted;
  assign shifted = mask >> from;
  assign idx     = zero_en ? from : seek_lane(mask, from, vl);
  assign zflag   = zero_en && (from < vl) && !shifted[0];
endmodule

// File: rtl/vec_step_seq.sv
module vec_step_seq
  import vss_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             done,
  input  logic [IDX_W-1:0] vl_in,
  input  logic [LANES-1:0] src_mask_in,
  input  logic [LANES-1:0] dst_mask_in,
  input  logic             pred_en,
  input  logic             twin_pred,
  input  logic             src_zero_en,
  input  logic             dst_zero_en,
  input  logic             in_vec,
  input  logic             out_vec,
  output logic [IDX_W-1:0] src_idx,
  output logic [IDX_W-1:0] dst_idx,
  output logic             src_zero,
  output logic             dst_zero,
  output logic             hold_pc,
  output logic             loop_end
);
  localparam int unsigned SIDES = 2;

  cfg_t cfg_next, cfg_q;
  idx_t vl_q;
  assign vl_q = cfg_q.vl;

  vss_cfg_latch u_cfg (
    .clk(clk), .rst(rst), .start(start), .vl_in(vl_in),
    .src_mask_in(src_mask_in), .dst_mask_in(dst_mask_in),
    .pred_en(pred_en), .twin_pred(twin_pred),
    .src_zero_en(src_zero_en), .dst_zero_en(dst_zero_en),
    .in_vec(in_vec), .out_vec(out_vec),
    .cfg_next(cfg_next), .cfg_q(cfg_q)
  );

  // side 0 = source, side 1 = destination
  idx_t  cur_idx  [SIDES];
  idx_t  cand_idx [SIDES];
  mask_t side_mask[SIDES];
  logic  side_zen [SIDES];
  idx_t  seek_idx [SIDES];
  logic  seek_z   [SIDES];

  assign cur_idx[0]   = src_idx;
  assign cur_idx[1]   = dst_idx;
  assign side_mask[0] = cfg_next.smask;
  assign side_mask[1] = cfg_next.dmask;
  assign side_zen[0]  = cfg_next.szero;
  assign side_zen[1]  = cfg_next.dzero;

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    assign cand_idx[g] = start ? '0 : cur_idx[g] + idx_t'(1);
    vss_lane_seek u_seek (
      .mask(side_mask[g]), .from(cand_idx[g]), .vl(cfg_next.vl),
      .zero_en(side_zen[g]), .idx(seek_idx[g]), .zflag(seek_z[g])
    );
  end

  // named events, also observed by the checker
  logic step_go, post_cont, land_out, evt_advance, evt_finish;
  assign step_go     = done && hold_pc && !start;
  assign post_cont   = cfg_q.vec && (src_idx != vl_q - idx_t'(1)) && (dst_idx != vl_q - idx_t'(1));
  assign land_out    = (seek_idx[0] == cfg_next.vl) || (seek_idx[1] == cfg_next.vl);
  assign evt_advance = (start || (step_go && post_cont)) && !land_out;
  assign evt_finish  = (start && land_out) || (step_go && (!post_cont || land_out));

  always_ff @(posedge clk) begin
    if (rst || evt_finish) begin
      src_idx  <= '0;
      dst_idx  <= '0;
      src_zero <= 1'b0;
      dst_zero <= 1'b0;
      hold_pc  <= 1'b0;
      loop_end <= !rst;
    end else if (evt_advance) begin
      src_idx  <= seek_idx[0];
      dst_idx  <= seek_idx[1];
      src_zero <= seek_z[0];
      dst_zero <= seek_z[1];
      hold_pc  <= 1'b1;
      loop_end <= 1'b0;
    end else begin
      loop_end <= 1'b0;
    end
  end
endmodule

// File: rtl/vss_sva.sv
module vss_sva
  import vss_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic start,
  input logic done,
  input idx_t src_idx,
  input idx_t dst_idx,
  input logic src_zero,
  input logic dst_zero,
  input logic hold_pc,
  input logic loop_end,
  input idx_t vl_q,
  input logic evt_advance,
  input logic evt_finish
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!hold_pc && !loop_end && src_idx == '0 && dst_idx == '0 && !src_zero && !dst_zero));

  a_r6_end_clears: assert property (@(posedge clk) disable iff (rst)
    loop_end |-> (!hold_pc && src_idx == '0 && dst_idx == '0 && !src_zero && !dst_zero));

  a_r6_finish_pulses: assert property (@(posedge clk) disable iff (rst)
    evt_finish |=> loop_end);

  a_r4_idx_below_vl: assert property (@(posedge clk) disable iff (rst)
    hold_pc |-> (src_idx < vl_q && dst_idx < vl_q));

  a_r5_flags_only_running: assert property (@(posedge clk) disable iff (rst)
    !hold_pc |-> (!src_zero && !dst_zero));

  a_r9_indices_grow: assert property (@(posedge clk) disable iff (rst)
    (evt_advance && !start) |=> (hold_pc && src_idx > $past(src_idx) && dst_idx > $past(dst_idx)));

  a_r10_idle_done_ignored: assert property (@(posedge clk) disable iff (rst)
    (!hold_pc && !start && done) |=> (!hold_pc && !loop_end));
endmodule

bind vec_step_seq vss_sva u_sva (
  .clk(clk), .rst(rst), .start(start), .done(done),
  .src_idx(src_idx), .dst_idx(dst_idx), .src_zero(src_zero), .dst_zero(dst_zero),
  .hold_pc(hold_pc), .loop_end(loop_end), .vl_q(vl_q),
  .evt_advance(evt_advance), .evt_finish(evt_finish)
);

// File: tb/vec_step_seq_tb.sv
module vec_step_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, done = 1'b0;
  logic [6:0] vl_in = '0;
  logic [NL-1:0] src_mask_in = '0, dst_mask_in = '0;
  logic pred_en = 0, twin_pred = 0, src_zero_en = 0, dst_zero_en = 0, in_vec = 0, out_vec = 0;
  logic [6:0] src_idx, dst_idx;
  logic src_zero, dst_zero, hold_pc, loop_end;

  int checks = 0;
  int errors = 0;

  // reference state
  int m_s, m_d, m_vl;
  bit m_zs, m_zd, m_hold, m_end, m_szc, m_dzc, m_vec;
  logic [NL-1:0] m_sm, m_dm;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_step_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .done(done), .vl_in(vl_in),
    .src_mask_in(src_mask_in), .dst_mask_in(dst_mask_in),
    .pred_en(pred_en), .twin_pred(twin_pred),
    .src_zero_en(src_zero_en), .dst_zero_en(dst_zero_en),
    .in_vec(in_vec), .out_vec(out_vec),
    .src_idx(src_idx), .dst_idx(dst_idx), .src_zero(src_zero), .dst_zero(dst_zero),
    .hold_pc(hold_pc), .loop_end(loop_end)
  );

  function automatic int ref_seek(logic [NL-1:0] m, int from, int vl);
    int i = from;
    while (i < vl && !m[i]) i++;
    return (i < vl) ? i : vl;
  endfunction

  task automatic m_finish();
    m_s = 0; m_d = 0; m_zs = 0; m_zd = 0; m_hold = 0; m_end = 1;
  endtask

  task automatic m_land(int fs, int fd);
    int ns, nd;
    ns = m_szc ? fs : ref_seek(m_sm, fs, m_vl);
    nd = m_dzc ? fd : ref_seek(m_dm, fd, m_vl);
    if (ns == m_vl || nd == m_vl) m_finish();
    else begin
      m_s = ns; m_d = nd; m_hold = 1; m_end = 0;
      m_zs = m_szc && !m_sm[fs];
      m_zd = m_dzc && !m_dm[fd];
    end
  endtask

  task automatic m_update();
    if (start) begin
      m_vl  = (int'(vl_in) > NL) ? NL : int'(vl_in);
      m_dm  = pred_en ? dst_mask_in : '1;
      m_sm  = !pred_en ? '1 : (twin_pred ? src_mask_in : dst_mask_in);
      m_szc = src_zero_en; m_dzc = dst_zero_en;
      m_vec = twin_pred ? (in_vec || out_vec) : out_vec;
      m_land(0, 0);
    end else if (done && m_hold) begin
      if (m_vec && m_s != m_vl - 1 && m_d != m_vl - 1) m_land(m_s + 1, m_d + 1);
      else m_finish();
    end else m_end = 0;
  endtask

  task automatic chk(string tag);
    checks++;
    if (int'(src_idx) != m_s || int'(dst_idx) != m_d || src_zero != m_zs || dst_zero != m_zd ||
        hold_pc != m_hold || loop_end != m_end) begin
      errors++;
      $display("FAIL %s: got s=%0d d=%0d zs=%0b zd=%0b hold=%0b end=%0b exp s=%0d d=%0d zs=%0b zd=%0b hold=%0b end=%0b",
               tag, src_idx, dst_idx, src_zero, dst_zero, hold_pc, loop_end,
               m_s, m_d, m_zs, m_zd, m_hold, m_end);
    end
  endtask

  task automatic cyc(bit st, bit dn, string tag);
    @(negedge clk);
    start = st; done = dn;
    m_update();
    @(posedge clk);
    #1;
    chk(tag);
    start = 0; done = 0;
  endtask

  task automatic setcfg(int vl, logic [NL-1:0] sm, logic [NL-1:0] dm,
                        bit pe, bit tw, bit sz, bit dz, bit iv, bit ov);
    vl_in = 7'(vl); src_mask_in = sm; dst_mask_in = dm;
    pred_en = pe; twin_pred = tw; src_zero_en = sz; dst_zero_en = dz;
    in_vec = iv; out_vec = ov;
  endtask

  function automatic logic [NL-1:0] rnd_mask(int kind);
    logic [NL-1:0] a, b;
    a = {$urandom, $urandom};
    b = {$urandom, $urandom};
    case (kind)
      0: return a | b;
      1: return a & b & {$urandom, $urandom};
      default: return '0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_s = 0; m_d = 0; m_zs = 0; m_zd = 0; m_hold = 0; m_end = 0; m_vl = 0;
    m_szc = 0; m_dzc = 0; m_vec = 0; m_sm = '0; m_dm = '0;
    repeat (3) @(posedge clk);
    #1; chk("R1 reset");
    @(negedge clk); rst = 0;

    // R7: zero length ends immediately
    setcfg(0, '1, '1, 0, 0, 0, 0, 1, 1);
    cyc(1, 0, "R7 vl zero");
    // R10: done while idle ignored
    cyc(0, 1, "R10 idle done");
    // R3: no predicate -> all ones
    setcfg(3, '0, '0, 0, 0, 0, 0, 0, 1);
    cyc(1, 0, "R3 no predicate");
    cyc(0, 1, "R2 step");
    // R10: restart mid loop; R3 single uses dst mask
    setcfg(8, 64'h1, 64'h8, 1, 0, 0, 0, 0, 1);
    cyc(1, 0, "R3 single mask");
    // R3 twin masks
    setcfg(8, 64'h2, 64'h4, 1, 1, 0, 0, 0, 1);
    cyc(1, 0, "R3 twin masks");
    // R5 source zeroing
    setcfg(8, 64'h2, 64'hFF, 1, 1, 1, 0, 0, 1);
    cyc(1, 0, "R5 zero flag");
    cyc(0, 1, "R5 zero clear");
    // R6 empty mask
    setcfg(5, '0, '0, 1, 0, 0, 0, 0, 1);
    cyc(1, 0, "R6 empty mask");
    // R4 bits beyond VL ignored
    setcfg(4, '0, 64'h102, 1, 0, 0, 0, 0, 1);
    cyc(1, 0, "R4 skip");
    cyc(0, 1, "R4 beyond vl");
    // R8 single predication with scalar output
    setcfg(6, '1, '1, 1, 0, 0, 0, 1, 0);
    cyc(1, 0, "R8 start");
    cyc(0, 1, "R8 scalar end");
    // R8 twin with vector input only keeps stepping
    setcfg(6, '1, '1, 1, 1, 0, 0, 1, 0);
    cyc(1, 0, "R8 twin start");
    cyc(0, 1, "R8 twin vector");
    // R9 vl=1 ends after one element
    setcfg(1, '1, '1, 0, 0, 0, 0, 0, 1);
    cyc(1, 0, "R9 vl one");
    cyc(0, 1, "R9 last lane");
    // R11 clamp
    setcfg(100, '0, '0, 0, 0, 0, 0, 0, 1);
    cyc(1, 0, "R11 clamp start");
    for (int k = 0; k < 64; k++) cyc(0, 1, "R11 clamp walk");

    // random mix
    for (int n = 0; n < 6000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (!m_hold || r < 3) begin
        setcfg($urandom_range(0, 70), rnd_mask($urandom_range(0, 2)), rnd_mask($urandom_range(0, 2)),
               1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0),
               1'($urandom), 1'($urandom_range(0, 4) != 0));
        cyc(1, 0, "R2 random start");
      end else if (r < 75) cyc(0, 1, "R9 random step");
      else cyc(0, 0, "R10 random idle");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule